// File: doc/BRIEF.md
# Serial Command Port with Interrupt Status

This block is the slave side of a byte-framed serial control link for a receiver-style peripheral. A host drives an active-low chip select, a serial clock and a data line. While chip select is low, data bits are taken on each rising serial-clock edge, most significant bit first. When chip select goes high the frame is judged as a whole. A well-formed write frame updates one of two 8-bit control registers. A well-formed read frame returns a 16-bit status word on the data-out line and clears the event flags it reported.

Four event inputs feed sticky flags: low supply, wake-up timeout, FIFO fill level and FIFO overflow. The active-low interrupt output is low while any enabled flag is set. The two FIFO flags count only when the FIFO-enable bit of the configuration register is set. All serial inputs are brought into the system clock domain through two-flop synchronisers. The system clock must run at least four times faster than the serial clock.

Top module: `serial_cmd_port`

## Requirements
- R1: After synchronous reset the configuration register reads 0x10, the threshold register reads 0x40, `irq_n_o` is 1 and `sdo_oe_o` is 0.
- R2: A 16-bit frame whose first byte is 0xA5 loads its second byte into the configuration register, and a first byte of 0xC3 loads the threshold register. Bits are taken at serial-clock rising edges, MSB first, and the update is applied when chip select rises.
- R3: A frame with fewer than 16 bits, or with a bit count that is not a multiple of 8, changes nothing. Raising chip select restarts framing, so the frame that follows decodes normally.
- R4: A 16-bit frame whose first bit is 1 and whose first byte is neither 0xA5 nor 0xC3 changes no register.
- R5: A frame whose first bit is 0 is a status read. `sdo_o` carries a 16-bit word MSB first, with the bits arranged as follows:
  - bit 15: low-supply flag
  - bit 14: wake-up flag
  - bit 13: fill-level flag
  - bit 12: overflow flag
  - bit 11: configuration bit 0 (FIFO enable)
  - bits 10:8: zero
  - bits 7:0: threshold register

  The first bit is valid before the first rising serial-clock edge. Each following bit is presented after a falling edge.
- R6: `sdo_oe_o` is 1 while chip select is low, after synchroniser delay, and 0 while it is high.
- R7: Event flags are sticky. A low-supply or wake-up event pulls `irq_n_o` low from the next system clock cycle onwards.
- R8: The fill-level and overflow flags pull `irq_n_o` low only while configuration bit 0 is 1. They are still held while the bit is 0, and they raise the interrupt once it is set.
- R9: When chip select rises after a status read of 16 bits or more that is a multiple of 8, all four flags clear and `irq_n_o` goes high. A read of 8 bits clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (high impedance when 0) |
| irq_n_o | output | 1 | Active-low interrupt request |
| ev_lowsup_i | input | 1 | Low-supply event |
| ev_wake_i | input | 1 | Wake-up timeout event |
| ev_fill_i | input | 1 | FIFO fill-level event |
| ev_ovf_i | input | 1 | FIFO overflow event |
| cfg_o | output | 8 | Configuration register |
| thr_o | output | 8 | Threshold register |

## Verification
A wrong bit counter or a stale input shift register appears at the ports when the next chip-select rise commits a frame: a register changes when it should not, or misses an update. A fault in the sticky flags shows on `irq_n_o` one system cycle after an event or a clear. It also shows in the next status word, where a wrong bit order or a missing flag is visible bit by bit on `sdo_o`. The bench therefore checks each register output and the interrupt within a few cycles of every frame end, and compares every bit of the status word.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 6;
    localparam int N_EVT    = 4;

    localparam logic [BYTE_W-1:0] CODE_CFG = 8'hA5;
    localparam logic [BYTE_W-1:0] CODE_THR = 8'hC3;
    localparam logic [BYTE_W-1:0] CFG_RST  = 8'h10;
    localparam logic [BYTE_W-1:0] THR_RST  = 8'h40;
    localparam int FIFO_EN_BIT = 0;

    typedef struct packed {
        logic lowsup;
        logic wake;
        logic fill;
        logic ovf;
    } evt_t;

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] arg;
    } cmd_t;

    function automatic logic [WORD_W-1:0] status_word(
        input evt_t flags, input logic fifo_en, input logic [BYTE_W-1:0] thr);
        return {flags, fifo_en, 3'b000, thr};
    endfunction

    function automatic logic [N_EVT-1:0] irq_mask(input logic fifo_en);
        return {1'b1, 1'b1, fifo_en, fifo_en};
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= RST_VAL;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= RST_VAL;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic [WORD_W-1:0] status_i,
    output logic              wr_stb_o,
    output logic              rd_done_o,
    output cmd_t              cmd_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int LSB_W = $clog2(BYTE_W);

    logic sck_q, csn_q;
    logic sck_rise, sck_fall, csn_fall, csn_rise;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] in_sr, out_sr;
    logic frame_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
        end
    end

    assign sck_rise = sck_s & ~sck_q & ~csn_s;
    assign sck_fall = ~sck_s & sck_q & ~csn_s;
    assign csn_fall = ~csn_s & csn_q;
    assign csn_rise = csn_s & ~csn_q;

    always_ff @(posedge clk) begin
        if (rst || csn_s)
            cnt <= '0;
        else if (sck_rise && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || csn_fall)
            in_sr <= '0;
        else if (sck_rise && cnt < CNT_W'(WORD_W))
            in_sr <= {in_sr[WORD_W-2:0], sdi_s};
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_sr <= '0;
        else if (csn_fall)
            out_sr <= status_i;
        else if (sck_fall)
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
    end

    assign frame_ok  = (cnt >= CNT_W'(WORD_W)) && (cnt[LSB_W-1:0] == '0);
    assign wr_stb_o  = csn_rise & frame_ok & in_sr[WORD_W-1];
    assign rd_done_o = csn_rise & frame_ok & ~in_sr[WORD_W-1];
    assign cmd_o     = cmd_t'(in_sr);
    assign sdo_o     = out_sr[WORD_W-1];
    assign sdo_oe_o  = ~csn_s;

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (cnt == '0));

    // R5
    snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        csn_fall |=> (sdo_o == $past(status_i[WORD_W-1])));
endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb_i,
    input  cmd_t              cmd_i,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [BYTE_W-1:0] thr_o
);
    logic hit_cfg, hit_thr;

    assign hit_cfg = wr_stb_i && (cmd_i.code == CODE_CFG);
    assign hit_thr = wr_stb_i && (cmd_i.code == CODE_THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= CFG_RST;
            thr_o <= THR_RST;
        end else begin
            if (hit_cfg) cfg_o <= cmd_i.arg;
            if (hit_thr) thr_o <= cmd_i.arg;
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb_i |=> $stable(cfg_o) && $stable(thr_o));
endmodule

// File: rtl/scp_irq.sv
module scp_irq
    import scp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t ev_i,
    input  logic clr_i,
    input  logic fifo_en_i,
    output evt_t flags_o,
    output logic irq_n_o
);
    evt_t flags_d;

    always_comb begin
        flags_d = evt_t'(flags_o & ~{N_EVT{clr_i}});
        flags_d = evt_t'(flags_d | ev_i);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= flags_d;
    end

    assign irq_n_o = ~|(flags_o & irq_mask(fifo_en_i));

    // R7
    evt_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_i.lowsup || ev_i.wake) |=> !irq_n_o);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && ev_i == '0) |=> (flags_o == '0) && irq_n_o);
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              irq_n_o,
    input  logic              ev_lowsup_i,
    input  logic              ev_wake_i,
    input  logic              ev_fill_i,
    input  logic              ev_ovf_i,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [BYTE_W-1:0] thr_o
);
    logic [2:0] raw, synced;
    logic wr_stb, rd_done;
    cmd_t cmd;
    evt_t ev, flags;
    logic fifo_en;

    assign raw = {sck_i, csn_i, sdi_i};

    scp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) i_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    scp_shifter i_shift (
        .clk(clk), .rst(rst),
        .sck_s(synced[2]), .csn_s(synced[1]), .sdi_s(synced[0]),
        .status_i(status_word(flags, fifo_en, thr_o)),
        .wr_stb_o(wr_stb), .rd_done_o(rd_done), .cmd_o(cmd),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    scp_regs i_regs (
        .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .cmd_i(cmd),
        .cfg_o(cfg_o), .thr_o(thr_o)
    );

    assign fifo_en = cfg_o[FIFO_EN_BIT];
    assign ev = '{lowsup: ev_lowsup_i, wake: ev_wake_i, fill: ev_fill_i, ovf: ev_ovf_i};

    scp_irq i_irq (
        .clk(clk), .rst(rst), .ev_i(ev), .clr_i(rd_done),
        .fifo_en_i(fifo_en), .flags_o(flags), .irq_n_o(irq_n_o)
    );

    // R8
    fifo_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !flags.lowsup && !flags.wake) |-> irq_n_o);
endmodule

// File: tb/test_serial_cmd_port.sv
module test_serial_cmd_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic ev_l = 0, ev_w = 0, ev_f = 0, ev_o = 0;
    logic sdo, sdo_oe, irq_n;
    logic [7:0] cfg, thr;
    int total = 0, bad = 0;
    logic [15:0] exp_q [$];
    logic [15:0] rx_word;
    logic oe_seen;
    event rd_ev;
    bit done = 0;

    always #5 clk = ~clk;

    serial_cmd_port i_serial_cmd_port (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_n_o(irq_n),
        .ev_lowsup_i(ev_l), .ev_wake_i(ev_w), .ev_fill_i(ev_f), .ev_ovf_i(ev_o),
        .cfg_o(cfg), .thr_o(thr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] bits, input int n);
        rx_word = '0;
        oe_seen = 1'b0;
        @(negedge clk); csn = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = bits[n-1-i];
            wait_n(5);
            if (i < 16) rx_word = {rx_word[14:0], sdo};
            if (sdo_oe) oe_seen = 1'b1;
            sck = 1'b1;
            wait_n(5);
            sck = 1'b0;
        end
        wait_n(5);
        csn = 1'b1;
        wait_n(8);
    endtask

    // driver: pushes expected status, runs a read frame
    task automatic read_status(input logic [15:0] exp);
        exp_q.push_back(exp);
        xfer(32'h0, 16);
        -> rd_ev;
        @(negedge clk);
    endtask

    task automatic pulse(input logic l, input logic w, input logic f, input logic o);
        @(negedge clk); ev_l = l; ev_w = w; ev_f = f; ev_o = o;
        @(negedge clk); ev_l = 0; ev_w = 0; ev_f = 0; ev_o = 0;
    endtask

    // monitor: compares each returned status word with the queue
    initial forever begin
        @(rd_ev);
        if (exp_q.size() == 0) chk("R5 queue", 16'h0, 16'h1);
        else chk("R5 status", rx_word, exp_q.pop_front());
    end

    initial begin
        wait_n(200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        chk("R1 cfg", {8'h0, cfg}, 16'h0010);
        chk("R1 thr", {8'h0, thr}, 16'h0040);
        chk("R1 irq_n", {15'h0, irq_n}, 16'h1);
        chk("R1 oe", {15'h0, sdo_oe}, 16'h0);

        // R2 writes
        xfer(32'hA501, 16);
        chk("R2 cfg", {8'h0, cfg}, 16'h0001);
        chk("R6 oe during frame", {15'h0, oe_seen}, 16'h1);
        chk("R6 oe idle", {15'h0, sdo_oe}, 16'h0);
        xfer(32'hC37E, 16);
        chk("R2 thr", {8'h0, thr}, 16'h007E);

        // R5 plain status
        read_status(16'h087E);

        // R3 non-byte frame discarded, next frame decodes
        xfer(32'hC31, 12);
        chk("R3 12-bit frame", {8'h0, thr}, 16'h007E);
        xfer(32'hC3, 8);
        chk("R3 8-bit frame", {8'h0, thr}, 16'h007E);
        xfer(32'hC35A, 16);
        chk("R3 restart", {8'h0, thr}, 16'h005A);

        // R4 unknown code
        xfer(32'hB055, 16);
        chk("R4 cfg", {8'h0, cfg}, 16'h0001);
        chk("R4 thr", {8'h0, thr}, 16'h005A);

        // R7 low-supply event
        pulse(1, 0, 0, 0);
        chk("R7 irq low", {15'h0, irq_n}, 16'h0);
        wait_n(10);
        chk("R7 sticky", {15'h0, irq_n}, 16'h0);
        read_status(16'h885A);
        chk("R9 irq released", {15'h0, irq_n}, 16'h1);

        // R8 masking of FIFO events
        xfer(32'hA500, 16);
        pulse(0, 0, 1, 0);
        wait_n(2);
        chk("R8 masked fill", {15'h0, irq_n}, 16'h1);
        xfer(32'hA501, 16);
        chk("R8 unmasked fill", {15'h0, irq_n}, 16'h0);
        read_status(16'h285A);
        chk("R9 cleared fill", {15'h0, irq_n}, 16'h1);

        // R9 short read clears nothing
        pulse(0, 1, 0, 0);
        xfer(32'h0, 8);
        chk("R9 short read", {15'h0, irq_n}, 16'h0);
        read_status(16'h485A);
        chk("R9 after full read", {15'h0, irq_n}, 16'h1);

        // R5 flag order with all events
        pulse(1, 1, 1, 1);
        read_status(16'hF85A);
        read_status(16'h085A);
        chk("R9 all cleared", {15'h0, irq_n}, 16'h1);

        wait_n(5);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule